// File: doc/BRIEF.md
# I2C Master Byte Buffering and Interrupt Unit

This unit sits between a host register port and an I2C master engine. It holds two byte queues: a transmit queue the host fills and the engine drains, and a receive queue the engine fills and the host drains. Each queue has a fill level that the host can read. A control write sets a high and a low threshold, and the same write can flush both queues.

A sticky status word merges queue-level conditions with engine events. These are done, address acknowledged, address not acknowledged, arbitration lost and bus error. An enable word masks the status word, and the result drives one interrupt line. The host clears status bits by writing ones to them.

All four byte paths are valid/ready streams. A transfer happens on a cycle where both valid and ready are high. The transmit input drops ready while its queue is full, so the producer must hold its byte until ready returns. The receive output drops valid while its queue is empty, so the consumer sees nothing to take. The consumer may hold ready low for as long as it likes without losing data.

Top module: `i2cm_fifo_hub`

## Requirements
- R1: Each queue holds DEPTH bytes (128 by default) and delivers them in the order they were accepted.
- R2: The transmit input shows ready low while its queue holds DEPTH bytes. An offered byte is then not stored and the level is unchanged. The receive output shows valid low while its queue is empty, and asserting ready then changes nothing. The next stored byte still comes out correctly.
- R3: `tx_level` and `rx_level` give the number of bytes held. A push and a pop in the same cycle leave the level unchanged.
- R4: A control write captures the high threshold from bits [15:8] and the low threshold from bits [7:0]. If bit 16 is also set, both queues are emptied and both levels read 0 after that edge. A control write without bit 16 leaves the contents alone.
- R5: Status and enable bit positions are: bus error 0, receive at/above high threshold 2, transmit became empty 3, transmit full 4, arbitration lost 11, done 12, address acknowledged 13, address not acknowledged 25. All other status bits read 0.
- R6: A status bit sets on the clock edge after its condition is seen. It then holds until it is cleared, even if the condition goes away.
- R7: Writing a 1 to a status bit through `clr_wr` clears it, and bits written as 0 are kept. A condition present in the clear cycle wins, so the bit stays set.
- R8: The high-threshold condition is true when the receive level is greater than or equal to the high threshold and the threshold is nonzero.
- R9: The empty condition fires once, when the transmit level goes from nonzero to zero. This covers both a pop and a flush.
- R10: The full condition is true in every cycle in which the transmit level equals DEPTH.
- R11: `irq` is high exactly when some status bit and its enable bit are both 1. It follows a status or enable update with no extra delay.
- R12: Each engine event input sets its own status bit and no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tx_in_valid | input | 1 | host offers a transmit byte |
| tx_in_ready | output | 1 | transmit queue can accept a byte |
| tx_in_data | input | 8 | transmit byte from the host |
| tx_out_valid | output | 1 | transmit byte available to the engine |
| tx_out_ready | input | 1 | engine takes the transmit byte |
| tx_out_data | output | 8 | oldest transmit byte |
| rx_in_valid | input | 1 | engine offers a received byte |
| rx_in_ready | output | 1 | receive queue can accept a byte |
| rx_in_data | input | 8 | received byte from the engine |
| rx_out_valid | output | 1 | received byte available to the host |
| rx_out_ready | input | 1 | host takes the received byte |
| rx_out_data | output | 8 | oldest received byte |
| tx_level | output | $clog2(DEPTH+1) | bytes held in the transmit queue |
| rx_level | output | $clog2(DEPTH+1) | bytes held in the receive queue |
| ctl_wr | input | 1 | control word write strobe |
| ctl_wdata | input | 17 | flush (16), high threshold (15:8), low threshold (7:0) |
| thr_hi | output | TH_W | current high threshold |
| thr_lo | output | TH_W | current low threshold |
| ev_done | input | 1 | engine transfer-done pulse |
| ev_addr_ack | input | 1 | engine address-acknowledged pulse |
| ev_addr_nack | input | 1 | engine address-not-acknowledged pulse |
| ev_arb_lost | input | 1 | engine arbitration-lost pulse |
| ev_bus_err | input | 1 | engine bus-error pulse |
| clr_wr | input | 1 | status clear strobe |
| clr_wdata | input | 32 | ones select status bits to clear |
| en_wr | input | 1 | enable word write strobe |
| en_wdata | input | 32 | new enable word |
| status | output | 32 | sticky status word |
| enable | output | 32 | current enable word |
| irq | output | 1 | interrupt line |

## Verification
Two pairs of functions can fall on the same clock edge, and both are provoked on purpose. In the first, a status clear is written in the same cycle as an engine event, or while the transmit queue is still full. The bench judges the result by reading the bit just after that edge: it must still be 1, because the set wins. In the second, the transmit queue gets a push and a pop in one cycle. The level must then read the same value before and after the edge, and the bytes must still come out in order.

// File: rtl/i2cm_fifo_pkg.sv
package i2cm_fifo_pkg;
  localparam int ST_W      = 32;
  localparam int CTL_W     = 17;
  localparam int CTL_FLUSH = 16;
  localparam int B_BUSERR  = 0;
  localparam int B_HITH    = 2;
  localparam int B_EMPTY   = 3;
  localparam int B_FULL    = 4;
  localparam int B_ARB     = 11;
  localparam int B_DONE    = 12;
  localparam int B_AACK    = 13;
  localparam int B_ANACK   = 25;

  localparam logic [ST_W-1:0] ST_IMPL =
    (ST_W'(1) << B_BUSERR) | (ST_W'(1) << B_HITH) | (ST_W'(1) << B_EMPTY) |
    (ST_W'(1) << B_FULL) | (ST_W'(1) << B_ARB) | (ST_W'(1) << B_DONE) |
    (ST_W'(1) << B_AACK) | (ST_W'(1) << B_ANACK);

  typedef struct packed {
    logic done;
    logic aack;
    logic anack;
    logic arb;
    logic buserr;
  } eng_ev_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DW-1:0]              in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DW-1:0]              out_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign in_ready  = (cnt != FULLV);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign level     = cnt;
  assign do_push   = in_valid && in_ready && !flush;
  assign do_pop    = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LASTP) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == LASTP) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/st_bank.sv
module st_bank
  import i2cm_fifo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic            clr_wr,
  input  logic [ST_W-1:0] clr_wdata,
  input  logic            en_wr,
  input  logic [ST_W-1:0] en_wdata,
  output logic [ST_W-1:0] st_q,
  output logic [ST_W-1:0] en_q,
  output logic            irq
);
  logic [ST_W-1:0] clr_m;

  assign clr_m = clr_wr ? clr_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= ((st_q & ~clr_m) | set_vec) & ST_IMPL;
      if (en_wr) en_q <= en_wdata;
    end
  end

  assign irq = |(st_q & en_q);
endmodule

// File: rtl/i2cm_fifo_hub.sv
module i2cm_fifo_hub
  import i2cm_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int TH_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_in_valid,
  output logic                       tx_in_ready,
  input  logic [7:0]                 tx_in_data,
  output logic                       tx_out_valid,
  input  logic                       tx_out_ready,
  output logic [7:0]                 tx_out_data,
  input  logic                       rx_in_valid,
  output logic                       rx_in_ready,
  input  logic [7:0]                 rx_in_data,
  output logic                       rx_out_valid,
  input  logic                       rx_out_ready,
  output logic [7:0]                 rx_out_data,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  input  logic                       ctl_wr,
  input  logic [16:0]                ctl_wdata,
  output logic [TH_W-1:0]            thr_hi,
  output logic [TH_W-1:0]            thr_lo,
  input  logic                       ev_done,
  input  logic                       ev_addr_ack,
  input  logic                       ev_addr_nack,
  input  logic                       ev_arb_lost,
  input  logic                       ev_bus_err,
  input  logic                       clr_wr,
  input  logic [31:0]                clr_wdata,
  input  logic                       en_wr,
  input  logic [31:0]                en_wdata,
  output logic [31:0]                status,
  output logic [31:0]                enable,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic            flush;
  logic            tx_was_empty;
  logic            tx_empty_now;
  logic [ST_W-1:0] set_vec;
  eng_ev_t         ev;

  assign flush = ctl_wr && ctl_wdata[CTL_FLUSH];

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_hi       <= '0;
      thr_lo       <= '0;
      tx_was_empty <= 1'b1;
    end else begin
      if (ctl_wr) begin
        thr_hi <= ctl_wdata[15:8];
        thr_lo <= ctl_wdata[7:0];
      end
      tx_was_empty <= tx_empty_now;
    end
  end

  assign tx_empty_now = (tx_level == '0);

  always_comb begin
    ev.done   = ev_done;
    ev.aack   = ev_addr_ack;
    ev.anack  = ev_addr_nack;
    ev.arb    = ev_arb_lost;
    ev.buserr = ev_bus_err;
    set_vec = '0;
    set_vec[B_BUSERR] = ev.buserr;
    set_vec[B_ARB]    = ev.arb;
    set_vec[B_DONE]   = ev.done;
    set_vec[B_AACK]   = ev.aack;
    set_vec[B_ANACK]  = ev.anack;
    set_vec[B_HITH]   = (thr_hi != '0) && (int'(rx_level) >= int'(thr_hi));
    set_vec[B_EMPTY]  = tx_empty_now && !tx_was_empty;
    set_vec[B_FULL]   = (tx_level == CW'(DEPTH));
  end

  st_bank u_st (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .st_q(status), .en_q(enable), .irq(irq)
  );
endmodule

// File: rtl/i2cm_fifo_hub_chk.sv
module i2cm_fifo_hub_chk
  import i2cm_fifo_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tx_in_valid,
  input logic                       tx_in_ready,
  input logic                       tx_out_ready,
  input logic                       tx_out_valid,
  input logic                       rx_out_valid,
  input logic [$clog2(DEPTH+1)-1:0] tx_level,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic                       ctl_wr,
  input logic [16:0]                ctl_wdata,
  input logic                       ev_done,
  input logic                       clr_wr,
  input logic [31:0]                clr_wdata,
  input logic [31:0]                status
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_level) <= DEPTH && int'(rx_level) <= DEPTH); // R1
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) == DEPTH) && tx_in_valid && !ctl_wr && !tx_out_ready
      |=> int'(tx_level) == DEPTH); // R2
  AST_EMPTY_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_out_valid); // R2
  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready && tx_out_valid && tx_out_ready && !ctl_wr
      |=> tx_level == $past(tx_level)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[16] |=> (tx_level == '0) && (rx_level == '0)); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~ST_IMPL) == '0); // R5
  AST_STICKY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_DONE] && !(clr_wr && clr_wdata[B_DONE]) |=> status[B_DONE]); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> status[B_DONE]); // R7
endmodule

bind i2cm_fifo_hub i2cm_fifo_hub_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
  .tx_out_ready(tx_out_ready), .tx_out_valid(tx_out_valid),
  .rx_out_valid(rx_out_valid), .tx_level(tx_level), .rx_level(rx_level),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ev_done(ev_done),
  .clr_wr(clr_wr), .clr_wdata(clr_wdata), .status(status)
);

// File: tb/sim_i2cm_fifo_hub.sv
module sim_i2cm_fifo_hub;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TH_W  = 8;
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rx_out_ready = 0;
  logic [7:0] tx_in_data = 0, rx_in_data = 0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic [CW-1:0] tx_level, rx_level;
  logic ctl_wr = 0;
  logic [16:0] ctl_wdata = 0;
  logic [TH_W-1:0] thr_hi, thr_lo;
  logic ev_done = 0, ev_addr_ack = 0, ev_addr_nack = 0, ev_arb_lost = 0, ev_bus_err = 0;
  logic clr_wr = 0, en_wr = 0;
  logic [31:0] clr_wdata = 0, en_wdata = 0;
  logic [31:0] status, enable;
  logic irq;

  int checks = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_fifo_hub #(.DEPTH(DEPTH), .TH_W(TH_W)) u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_in_valid = 1; tx_in_data = b; tick(); tx_in_valid = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_in_valid = 1; rx_in_data = b; tick(); rx_in_valid = 0;
  endtask

  task automatic ctl(input logic fl, input logic [7:0] hi, input logic [7:0] lo);
    ctl_wr = 1; ctl_wdata = {fl, hi, lo}; tick(); ctl_wr = 0;
  endtask

  task automatic clr(input logic [31:0] m);
    clr_wr = 1; clr_wdata = m; tick(); clr_wr = 0;
  endtask

  task automatic set_en(input logic [31:0] m);
    en_wr = 1; en_wdata = m; tick(); en_wr = 0;
  endtask

  task automatic pulse_ev(input int p);
    case (p)
      0:  ev_bus_err = 1;
      11: ev_arb_lost = 1;
      12: ev_done = 1;
      13: ev_addr_ack = 1;
      default: ev_addr_nack = 1;
    endcase
    tick();
    {ev_bus_err, ev_arb_lost, ev_done, ev_addr_ack, ev_addr_nack} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int evpos [5] = '{12, 13, 25, 11, 0};
    tick(); tick();
    rst_n = 1;
    tick();
    // reset state
    check("R3 reset tx_level", 32'(tx_level), 0);
    check("R3 reset rx_level", 32'(rx_level), 0);
    check("R6 reset status", status, 0);
    check("R11 reset irq", 32'(irq), 0);
    check("R2 reset tx ready", 32'(tx_in_ready), 1);
    check("R2 reset rx valid", 32'(rx_out_valid), 0);

    // TX fill sweep, full, blocked push
    for (int i = 0; i < DEPTH; i++) begin
      push_tx(8'(8'h30 + i*7));
      check("R3 tx level during fill", 32'(tx_level), 32'(i+1));
    end
    tick();
    check("R10 full bit", 32'(status[4]), 1);
    check("R2 ready low when full", 32'(tx_in_ready), 0);
    push_tx(8'hEE);
    check("R2 blocked push keeps level", 32'(tx_level), DEPTH);
    clr(32'hFFFF_FFFF);
    check("R7 persisting full wins over clear", 32'(status[4]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R1 tx order", 32'(tx_out_data), 32'(8'(8'h30 + i*7)));
      tx_out_ready = 1; tick(); tx_out_ready = 0;
    end
    tick();
    check("R9 empty edge after last pop", 32'(status[3]), 1);
    check("R6 full bit held after draining", 32'(status[4]), 1);

    // simultaneous push and pop
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    tx_in_valid = 1; tx_in_data = 8'h04; tx_out_ready = 1;
    tick();
    tx_in_valid = 0; tx_out_ready = 0;
    check("R3 push+pop keeps level", 32'(tx_level), 3);
    check("R1 order after push+pop", 32'(tx_out_data), 8'h02);
    clr(32'hFFFF_FFFF);
    ctl(1'b1, 8'd0, 8'd0);
    tick();
    check("R9 empty edge on flush", 32'(status[3]), 1);

    // high threshold sweep
    for (int th = 0; th <= DEPTH; th++) begin
      ctl(1'b1, 8'(th), 8'd0);
      clr(32'hFFFF_FFFF);
      for (int k = 1; k <= DEPTH; k++) begin
        push_rx(8'(k));
        tick();
        check("R8 high threshold flag", 32'(status[2]),
              32'((th != 0) && (k >= th)));
      end
    end
    for (int k = 1; k <= DEPTH; k++) begin
      check("R1 rx order", 32'(rx_out_data), 32'(k));
      rx_out_ready = 1; tick(); rx_out_ready = 0;
    end
    check("R2 rx valid low when empty", 32'(rx_out_valid), 0);
    rx_out_ready = 1; tick(); rx_out_ready = 0;
    check("R2 empty pop keeps level", 32'(rx_level), 0);
    push_rx(8'hA5);
    check("R2 data after empty pop", 32'(rx_out_data), 8'hA5);

    // engine events, enables, irq, clear
    ctl(1'b1, 8'd0, 8'd0);
    clr(32'hFFFF_FFFF);
    foreach (evpos[j]) begin
      clr(32'hFFFF_FFFF);
      set_en(0);
      pulse_ev(evpos[j]);
      check("R12 R5 event sets own bit only", status, 32'(1) << evpos[j]);
      check("R11 masked irq low", 32'(irq), 0);
      set_en(32'(1) << evpos[j]);
      check("R11 enabled irq high", 32'(irq), 1);
      set_en(~(32'(1) << evpos[j]));
      check("R11 other enables irq low", 32'(irq), 0);
      clr(~(32'(1) << evpos[j]));
      check("R6 clear of other bits keeps bit", status, 32'(1) << evpos[j]);
      clr(32'(1) << evpos[j]);
      check("R7 write one clears", status, 0);
    end
    ev_done = 1; clr_wr = 1; clr_wdata = 32'(1) << 12;
    tick();
    ev_done = 0; clr_wr = 0;
    check("R7 event wins same-cycle clear", 32'(status[12]), 1);

    // control word and flush
    push_tx(8'h11); push_tx(8'h22);
    push_rx(8'h33); push_rx(8'h44); push_rx(8'h55);
    ctl(1'b1, 8'd5, 8'd9);
    check("R4 flush tx", 32'(tx_level), 0);
    check("R4 flush rx", 32'(rx_level), 0);
    check("R4 hi captured", 32'(thr_hi), 5);
    check("R4 lo captured", 32'(thr_lo), 9);
    push_rx(8'h66);
    ctl(1'b0, 8'd6, 8'd2);
    check("R4 no-flush write keeps rx", 32'(rx_level), 1);
    check("R4 hi updated", 32'(thr_hi), 6);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule